// File: doc/BRIEF.md
# Multiple Register Load Sequencer

This block copies a run of consecutive words into consecutive general registers. A start pulse supplies the first destination register, a 17-bit word address and the current 4-bit condition code, and that code sets how many words move. A value of zero means a full block of sixteen. For each word the sequencer issues one read over a valid/ready request channel, waits for the matching response, and writes the returned word into the 16-entry register file it owns. Both the register number and the word address then advance by one. The register number wraps from 15 back to 0.

Some word addresses name the register file itself rather than memory. The sequencer tests every word's address separately. For each such word it reads the register file directly and sends nothing to memory. Every memory response carries two fault flags, one for protection and one for a nonexistent region. If either flag is set, the run stops with a trap: the faulting address is reported, no further registers change, and registers already loaded keep their new contents. A side port lets the surrounding core preload registers and read them back.

Top module: `mrl_top`

## Requirements
- R1: The number of registers loaded equals the condition code sampled at the accepted start. Code 4'b0000 loads 16 words.
- R2: Word k of a run (k = 0, 1, ...) comes from word address start_addr+k and is written to register start_reg+k.
- R3: Destination register numbers are taken modulo 16, so the register loaded after 15 is 0.
- R4: A word whose address is below 16 is taken from the register with that number. No memory request is issued for that word. Words at 16 or above are read from memory.
- R5: A response with mem_rsp_prot_fault or mem_rsp_nxm_fault set ends the run. The trap output goes to 1, trap_addr holds that word's address, and the faulting word and all later words are not written. Earlier words stay written. An accepted start clears trap to 0.
- R6: busy goes to 1 in the cycle after an accepted start and stays at 1 until the run ends. A start pulse while busy is 1 has no effect on the run.
- R7: Only one memory request is outstanding at any time. While mem_req_valid is 1 and mem_req_ready is 0, the request and its address stay unchanged in the next cycle.
- R8: done is a one-cycle pulse at the end of every run, whether the run completes or traps. In the cycle after done, busy is 0.
- R9: After reset, busy, done, trap and mem_req_valid are 0.
- R10: The side write port (rf_wr_en, rf_wr_idx, rf_wr_data) updates a register only while busy is 0. A side write attempted during a run has no effect. rf_rd_data always shows register rf_rd_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Start pulse, accepted only while idle |
| start_reg | input | 4 | First destination register |
| start_addr | input | 17 | Word address of the first source word |
| cc | input | 4 | Condition code used as the word count (0 means 16) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| trap | output | 1 | Last run ended on an access fault |
| trap_addr | output | 17 | Address of the faulting word |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 17 | Requested word address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response word |
| mem_rsp_prot_fault | input | 1 | Response hit a protected region |
| mem_rsp_nxm_fault | input | 1 | Response hit a nonexistent region |
| rf_wr_en | input | 1 | Side register write enable |
| rf_wr_idx | input | 4 | Side write register number |
| rf_wr_data | input | 32 | Side write data |
| rf_rd_idx | input | 4 | Side read register number |
| rf_rd_data | output | 32 | Side read data |

## Verification
The bench builds the block with its default sizes: 32-bit words, 17-bit addresses and a 16-entry register file. At that size the bench can sweep all 256 pairs of start register and count. Every wrap point of the register number and every run length from 1 to 16 is therefore covered, and all sixteen registers are compared after each run. Runs whose addresses start below 16, or cross the boundary at 16, use the register-file path and the memory path within one run. Faults placed at chosen word positions, together with stall and latency patterns in the memory model, exercise the trap and handshake corners.

// File: rtl/mrl_pkg.sv
package mrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } mrl_state_e;
endpackage

// File: rtl/mrl_regfile.sv
module mrl_regfile #(
  parameter int DATA_W = 32,
  parameter int REG_N  = 16,
  localparam int IDX_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] mem_q [REG_N];

  // storage array: no reset, each entry has its own write enable
  always_ff @(posedge clk) begin
    for (int i = 0; i < REG_N; i++) begin
      if (we && (widx == IDX_W'(i))) begin
        mem_q[i] <= wdata;
      end
    end
  end

  assign ra_data = mem_q[ra_idx];
  assign rb_data = mem_q[rb_idx];
endmodule

// File: rtl/mrl_ctrl.sv
module mrl_ctrl
  import mrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_ok,
  input  logic       low_hit,
  input  logic       req_ready,
  input  logic       rsp_valid,
  input  logic       rsp_fault,
  input  logic       last,
  output mrl_state_e state
);
  mrl_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:  if (start_ok) state_d = ST_ISSUE;
      ST_ISSUE: begin
        if (low_hit)        state_d = ST_WRITE;
        else if (req_ready) state_d = ST_WAIT;
      end
      ST_WAIT:  if (rsp_valid) state_d = rsp_fault ? ST_DONE : ST_WRITE;
      ST_WRITE: state_d = last ? ST_DONE : ST_ISSUE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/mrl_datapath.sv
module mrl_datapath
  import mrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 17,
  parameter int REG_N  = 16,
  localparam int IDX_W = $clog2(REG_N),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mrl_state_e        state,
  input  logic              load,
  input  logic [IDX_W-1:0]  start_reg,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [IDX_W-1:0]  cc,
  input  logic              rsp_valid,
  input  logic              rsp_fault,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [DATA_W-1:0] rf_src,
  output logic [IDX_W-1:0]  cur_reg,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] word_q,
  output logic              low_hit,
  output logic              last,
  output logic              trap_q,
  output logic [ADDR_W-1:0] trap_addr_q
);
  logic [CNT_W-1:0] remain_q;
  logic             step_en;
  logic             cap_local;
  logic             cap_mem;
  logic             cap_fault;

  assign low_hit   = cur_addr < ADDR_W'(REG_N);
  assign last      = remain_q == CNT_W'(1);
  assign step_en   = state == ST_WRITE;
  assign cap_local = (state == ST_ISSUE) && low_hit;
  assign cap_mem   = (state == ST_WAIT) && rsp_valid && !rsp_fault;
  assign cap_fault = (state == ST_WAIT) && rsp_valid && rsp_fault;

  // run position: register, address and words left
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_reg  <= '0;
      cur_addr <= '0;
      remain_q <= '0;
    end else if (load) begin
      cur_reg  <= start_reg;
      cur_addr <= start_addr;
      remain_q <= (cc == '0) ? CNT_W'(REG_N) : {1'b0, cc};
    end else if (step_en) begin
      cur_reg  <= cur_reg + IDX_W'(1);
      cur_addr <= cur_addr + ADDR_W'(1);
      remain_q <= remain_q - CNT_W'(1);
    end
  end

  // fetched word holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word_q <= '0;
    else if (cap_local) word_q <= rf_src;
    else if (cap_mem)   word_q <= rsp_data;
  end

  // trap status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q      <= 1'b0;
      trap_addr_q <= '0;
    end else if (load) begin
      trap_q      <= 1'b0;
    end else if (cap_fault) begin
      trap_q      <= 1'b1;
      trap_addr_q <= cur_addr;
    end
  end
endmodule

// File: rtl/mrl_top.sv
module mrl_top
  import mrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 17,
  parameter int REG_N  = 16,
  localparam int IDX_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_reg,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [IDX_W-1:0]  cc,
  output logic              busy,
  output logic              done,
  output logic              trap,
  output logic [ADDR_W-1:0] trap_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_prot_fault,
  input  logic              mem_rsp_nxm_fault,
  input  logic              rf_wr_en,
  input  logic [IDX_W-1:0]  rf_wr_idx,
  input  logic [DATA_W-1:0] rf_wr_data,
  input  logic [IDX_W-1:0]  rf_rd_idx,
  output logic [DATA_W-1:0] rf_rd_data
);
  logic              rst_meta;
  logic              rst_q;
  mrl_state_e        state;
  logic              start_ok;
  logic              low_hit;
  logic              last;
  logic              rsp_fault;
  logic [IDX_W-1:0]  cur_reg;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] rf_src;
  logic              seq_we;
  logic              side_we;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  assign start_ok  = start && (state == ST_IDLE);
  assign rsp_fault = mem_rsp_prot_fault || mem_rsp_nxm_fault;
  assign seq_we    = state == ST_WRITE;
  assign side_we   = rf_wr_en && (state == ST_IDLE);
  assign wr_en     = seq_we || side_we;
  assign wr_idx    = seq_we ? cur_reg : rf_wr_idx;
  assign wr_data   = seq_we ? word_q  : rf_wr_data;

  mrl_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_q),
    .start_ok  (start_ok),
    .low_hit   (low_hit),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .rsp_fault (rsp_fault),
    .last      (last),
    .state     (state)
  );

  mrl_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .REG_N  (REG_N)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_q),
    .state       (state),
    .load        (start_ok),
    .start_reg   (start_reg),
    .start_addr  (start_addr),
    .cc          (cc),
    .rsp_valid   (mem_rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_data    (mem_rsp_data),
    .rf_src      (rf_src),
    .cur_reg     (cur_reg),
    .cur_addr    (cur_addr),
    .word_q      (word_q),
    .low_hit     (low_hit),
    .last        (last),
    .trap_q      (trap),
    .trap_addr_q (trap_addr)
  );

  mrl_regfile #(
    .DATA_W (DATA_W),
    .REG_N  (REG_N)
  ) u_rf (
    .clk     (clk),
    .we      (wr_en),
    .widx    (wr_idx),
    .wdata   (wr_data),
    .ra_idx  (rf_rd_idx),
    .ra_data (rf_rd_data),
    .rb_idx  (cur_addr[IDX_W-1:0]),
    .rb_data (rf_src)
  );

  assign busy          = (state != ST_IDLE);
  assign done          = (state == ST_DONE);
  assign mem_req_valid = (state == ST_ISSUE) && !low_hit;
  assign mem_req_addr  = cur_addr;
endmodule

// File: rtl/mrl_checker.sv
module mrl_checker #(
  parameter int ADDR_W = 17,
  parameter int REG_N  = 16,
  localparam int IDX_W = $clog2(REG_N),
  localparam int CNT_W = IDX_W + 1
) (
  input logic              clk,
  input logic              rst_q,
  input logic              start_ok,
  input logic [IDX_W-1:0]  cc,
  input logic              busy,
  input logic              done,
  input logic              trap,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              seq_we,
  input logic [IDX_W-1:0]  wr_idx
);
  logic             outstanding;
  logic             have_prev;
  logic [IDX_W-1:0] prev_idx;
  logic [CNT_W-1:0] exp_n;
  logic [CNT_W-1:0] wr_cnt;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      outstanding <= 1'b0;
      have_prev   <= 1'b0;
      prev_idx    <= '0;
      exp_n       <= '0;
      wr_cnt      <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
      else if (mem_rsp_valid)             outstanding <= 1'b0;
      if (start_ok) begin
        have_prev <= 1'b0;
        wr_cnt    <= '0;
        exp_n     <= (cc == '0) ? CNT_W'(REG_N) : {1'b0, cc};
      end else if (seq_we) begin
        have_prev <= 1'b1;
        prev_idx  <= wr_idx;
        wr_cnt    <= wr_cnt + CNT_W'(1);
      end
    end
  end

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_q)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_q)
    outstanding |-> !mem_req_valid);

  assert_low_addr_local_R4: assert property (@(posedge clk) disable iff (!rst_q)
    mem_req_valid |-> mem_req_addr >= ADDR_W'(REG_N));

  assert_reg_wrap_R3: assert property (@(posedge clk) disable iff (!rst_q)
    seq_we && have_prev |-> wr_idx == prev_idx + IDX_W'(1));

  assert_write_limit_R1: assert property (@(posedge clk) disable iff (!rst_q)
    seq_we |-> wr_cnt < exp_n);

  assert_full_count_R1: assert property (@(posedge clk) disable iff (!rst_q)
    done && !trap |-> wr_cnt == exp_n);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> !done && !busy);

  assert_trap_no_write_R5: assert property (@(posedge clk) disable iff (!rst_q)
    trap && busy |-> !seq_we);
endmodule

bind mrl_top mrl_checker #(
  .ADDR_W (ADDR_W),
  .REG_N  (REG_N)
) u_chk (
  .clk           (clk),
  .rst_q         (rst_q),
  .start_ok      (start_ok),
  .cc            (cc),
  .busy          (busy),
  .done          (done),
  .trap          (trap),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .seq_we        (seq_we),
  .wr_idx        (wr_idx)
);

// File: tb/test_mrl_top.sv
module test_mrl_top;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  start_reg;
  logic [16:0] start_addr;
  logic [3:0]  cc;
  logic        busy, done, trap;
  logic [16:0] trap_addr;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [16:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        mem_rsp_prot_fault, mem_rsp_nxm_fault;
  logic        rf_wr_en;
  logic [3:0]  rf_wr_idx;
  logic [31:0] rf_wr_data;
  logic [3:0]  rf_rd_idx;
  logic [31:0] rf_rd_data;

  int n_chk  = 0;
  int n_fail = 0;

  // memory model state
  int          flt_addr = -1;
  int          flt_kind = 0;
  int          n_req    = 0;
  bit          pend     = 0;
  int          dly      = 0;
  int          stall    = 0;
  logic [16:0] paddr    = '0;
  logic [16:0] laddr    = '0;

  mrl_top i_mrl_top (
    .clk(clk), .rst_n(rst_n), .start(start), .start_reg(start_reg),
    .start_addr(start_addr), .cc(cc), .busy(busy), .done(done), .trap(trap),
    .trap_addr(trap_addr), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_prot_fault(mem_rsp_prot_fault), .mem_rsp_nxm_fault(mem_rsp_nxm_fault),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [16:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h3C0000C3 ^ {15'd0, a};
  endfunction

  function automatic logic [31:0] pre_val(input int seed, input int i);
    return 32'hA5000000 | 32'((seed & 255) << 8) | 32'(i);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model, driven away from the active edge
  always @(negedge clk) begin
    mem_rsp_valid      = 1'b0;
    mem_rsp_prot_fault = 1'b0;
    mem_rsp_nxm_fault  = 1'b0;
    if (!rst_n) begin
      mem_req_ready = 1'b0;
      pend = 0;
    end else if (mem_req_ready) begin
      mem_req_ready = 1'b0;
      pend  = 1;
      paddr = laddr;
      dly   = n_req % 2;
      n_req++;
    end else if (pend) begin
      if (dly == 0) begin
        mem_rsp_valid      = 1'b1;
        mem_rsp_data       = mem_word(paddr);
        mem_rsp_prot_fault = (flt_kind == 1) && (int'(paddr) == flt_addr);
        mem_rsp_nxm_fault  = (flt_kind == 2) && (int'(paddr) == flt_addr);
        pend = 0;
      end else dly--;
    end else if (mem_req_valid) begin
      if (stall == 0) begin
        mem_req_ready = 1'b1;
        laddr = mem_req_addr;
        stall = (n_req * 7) % 3;
      end else stall--;
    end
  end

  task automatic run_op(input int r, input int a, input int c, input int fa,
                        input int fk, input bit poke, input string req);
    logic [31:0] pre [16];
    logic [31:0] exp [16];
    int   n, exp_req, n_done, wait_cyc;
    bit   exp_trap;
    logic [16:0] exp_taddr, ad;
    // preload through the side port
    for (int i = 0; i < 16; i++) begin
      pre[i] = pre_val(r * 16 + c + a, i);
      exp[i] = pre[i];
      @(negedge clk);
      rf_wr_en = 1'b1; rf_wr_idx = 4'(i); rf_wr_data = pre[i];
    end
    @(negedge clk);
    rf_wr_en = 1'b0;
    // expected result
    n = (c == 0) ? 16 : c;
    exp_req = 0; exp_trap = 0; exp_taddr = '0;
    for (int k = 0; k < n; k++) begin
      ad = 17'(a + k);
      if (ad >= 17'd16) begin
        exp_req++;
        if (fk != 0 && int'(ad) == fa) begin
          exp_trap = 1; exp_taddr = ad;
          break;
        end
        exp[(r + k) % 16] = mem_word(ad);
      end else begin
        exp[(r + k) % 16] = pre[ad[3:0]];
      end
    end
    flt_addr = fa; flt_kind = fk; n_req = 0;
    start = 1'b1; start_reg = 4'(r); start_addr = 17'(a); cc = 4'(c);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6", "busy after start", 32'(busy), 32'd1);
    if (poke) begin
      start = 1'b1; start_reg = 4'(r + 3); start_addr = 17'h00400; cc = 4'd1;
      rf_wr_en = 1'b1; rf_wr_idx = 4'(r + 15); rf_wr_data = 32'hDEADBEEF;
      @(negedge clk);
      start = 1'b0; rf_wr_en = 1'b0;
    end
    n_done = 0; wait_cyc = 0;
    while (busy && wait_cyc < 400) begin
      if (done) n_done++;
      @(negedge clk);
      wait_cyc++;
    end
    check(n_done == 1, "R8", "done pulse count", 32'(n_done), 32'd1);
    check(busy == 1'b0 && done == 1'b0, "R8", "idle after done",
          {30'd0, busy, done}, 32'd0);
    check(trap == exp_trap, "R5", "trap flag", 32'(trap), 32'(exp_trap));
    if (exp_trap)
      check(trap_addr == exp_taddr, "R5", "trap address",
            32'(trap_addr), 32'(exp_taddr));
    check(n_req == exp_req, "R4", "memory request count", 32'(n_req), 32'(exp_req));
    for (int i = 0; i < 16; i++) begin
      rf_rd_idx = 4'(i);
      #1;
      check(rf_rd_data == exp[i], req, $sformatf("register %0d", i),
            rf_rd_data, exp[i]);
    end
    flt_kind = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start_reg = '0; start_addr = '0; cc = '0;
    rf_wr_en = 1'b0; rf_wr_idx = '0; rf_wr_data = '0; rf_rd_idx = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    mem_rsp_prot_fault = 1'b0; mem_rsp_nxm_fault = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check(busy == 0 && done == 0 && trap == 0 && mem_req_valid == 0, "R9",
          "reset outputs", {28'd0, busy, done, trap, mem_req_valid}, 32'd0);
    // R1 R2 R3: every start register with every count
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        run_op(r, 256 + r * 37 + c, c, -1, 0, 0, "R1_R2_R3");
    // R4: sources fully inside the register file, no overlap
    run_op(8, 0, 4, -1, 0, 0, "R4");
    run_op(0, 10, 6, -1, 0, 0, "R4");
    // R4: run crossing from register file to memory
    run_op(2, 14, 4, -1, 0, 0, "R4");
    // R5: protection fault on third word, nonexistent region on first word
    run_op(5, 1000, 6, 1002, 1, 0, "R5");
    run_op(13, 2000, 0, 2000, 2, 0, "R5");
    run_op(14, 3000, 5, 3004, 2, 0, "R5");
    // R5: trap cleared by the next accepted start
    run_op(1, 4000, 2, -1, 0, 0, "R5");
    // R6 R10: start and side write during a run have no effect
    run_op(6, 5000, 7, -1, 0, 1, "R6_R10");
    run_op(12, 6000, 15, -1, 0, 1, "R6_R10");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule